// File: doc/BRIEF.md
# Programmable System Clock Divider

The block produces a clock enable that paces the processor, the bus masters and the on-chip peripherals from one base clock. A 3-bit divide-select value chooses either full speed, where the enable is high on every base clock, or a divided rate, where the enable is a single-cycle pulse once every 2, 4, 8, 16 or 32 base clocks. A divided-mode flag shows whether the enable currently runs at less than full speed.

Software writes the select value at any time. The write is only staged, and the rate in effect changes at the next clock edge where the bus reports that a bus cycle is ending. A transfer that is in flight therefore always completes at the rate it started with. Any reset drops the block back to full speed and clears the staged value. When the rate changes, the internal divide counter restarts, so the first divided period after a switch is a whole period.

Top module: `sysclk_divider`

## Requirements
- R1: While and after `rst_n` is low, `div_active` is 0, `clk_en` is 1 on every base clock, and the staged selection is 000, so a later `bus_end` with no new write keeps full speed.
- R2: With selection code 1, 2, 3, 4 or 5 in effect, `clk_en` is high for one base clock out of every 2, 4, 8, 16 or 32 (2 to the power of the code).
- R3: With code 000 in effect, `clk_en` is 1 on every base clock.
- R4: Codes 110 and 111 act exactly like 000.
- R5: A write (`sel_we` high) stages `sel_wdata`; the rate in effect changes only at a rising clock edge where `bus_end` is high, and then takes the value staged before that edge. A write in the same cycle as `bus_end` waits for the next `bus_end`.
- R6: Returning to full speed by writing 000 also waits for `bus_end`; until then the divided pattern continues unchanged.
- R7: When a `bus_end` edge changes the rate to 2^k, the first `clk_en` pulse comes in the 2^k-th base clock after that edge (cycle index 2^k-1, counting the first cycle after the edge as 0).
- R8: In divided mode `clk_en` is never high for two base clocks in a row.
- R9: A `bus_end` edge that does not change the rate leaves the pulse phase undisturbed.
- R10: `div_active` is 1 exactly when the rate in effect is not full speed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low reset (pin or watchdog), asynchronous assert |
| sel_wdata | input | 3 | Divide-select value to stage |
| sel_we | input | 1 | Write strobe for `sel_wdata` |
| bus_end | input | 1 | High in the last cycle of a bus cycle |
| clk_en | output | 1 | Divided clock enable |
| div_active | output | 1 | High while a divided rate is in effect |

## Verification
The hardest case to reach from the ports is a staged selection that sits waiting while the old rate keeps running, in particular a write that lands in the very cycle of a `bus_end` and must be held over to the next one. The bench drives the write and `bus_end` strobes at chosen cycle indices inside one observation window, so a write can be placed with no following `bus_end`, on the same edge as one, or a `bus_end` can be placed mid-period with nothing staged, while the enable pattern is checked cycle by cycle against a phase computed in the bench.

// File: rtl/sysclk_div_pkg.sv
package sysclk_div_pkg;

  // Largest valid shift (divide by 2**MAX) and width of the select field.
  localparam int unsigned SEL_WIDTH = 3;
  localparam int unsigned SHIFT_MAX = 5;

  // Map a raw select code to the shift actually applied; reserved codes
  // collapse to full speed.
  function automatic int unsigned legal_shift(input int unsigned code,
                                              input int unsigned max_shift);
    if (code <= max_shift) return code;
    return 0;
  endfunction

  // Terminal count of the divide counter for a given shift.
  function automatic int unsigned period_last(input int unsigned shift);
    return (32'd1 << shift) - 32'd1;
  endfunction

endpackage

// File: rtl/sysclk_div_selreg.sv
module sysclk_div_selreg
  import sysclk_div_pkg::*;
#(
  parameter int unsigned SEL_W   = SEL_WIDTH,
  parameter int unsigned MAX_SH  = SHIFT_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] wr_data,
  input  logic             wr_en,
  input  logic             bus_end,
  output logic [SEL_W-1:0] active_shift,
  output logic             switch_evt
);

  logic [SEL_W-1:0] staged_q;
  logic [SEL_W-1:0] active_q;
  logic [SEL_W-1:0] wr_norm;

  assign wr_norm      = SEL_W'(legal_shift(int'(wr_data), MAX_SH));
  assign switch_evt   = bus_end && (staged_q != active_q);
  assign active_shift = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_q <= '0;
    end else if (wr_en) begin
      staged_q <= wr_norm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
    end else if (bus_end) begin
      active_q <= staged_q;
    end
  end

  // R5
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_end |=> $stable(active_q));

  // R5
  same_cycle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_end) |=> (active_q == $past(staged_q)));

  // R4
  legal_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q <= SEL_W'(MAX_SH));

endmodule

// File: rtl/sysclk_div_counter.sv
module sysclk_div_counter #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] last,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == last);
  assign tick    = !run || at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart || !run || at_last) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R7
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !restart) |=> !tick);

endmodule

// File: rtl/sysclk_divider.sv
module sysclk_divider
  import sysclk_div_pkg::*;
#(
  parameter int unsigned SEL_W  = SEL_WIDTH,
  parameter int unsigned MAX_SH = SHIFT_MAX,
  localparam int unsigned CNT_W = (MAX_SH < 1) ? 1 : MAX_SH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic             sel_we,
  input  logic             bus_end,
  output logic             clk_en,
  output logic             div_active
);

  logic [SEL_W-1:0] active_shift;
  logic             switch_evt;
  logic [CNT_W-1:0] last_cnt;
  logic             run;

  sysclk_div_selreg #(
    .SEL_W  (SEL_W),
    .MAX_SH (MAX_SH)
  ) u_selreg (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_data      (sel_wdata),
    .wr_en        (sel_we),
    .bus_end      (bus_end),
    .active_shift (active_shift),
    .switch_evt   (switch_evt)
  );

  assign run      = (active_shift != '0);
  assign last_cnt = CNT_W'(period_last(int'(active_shift)));

  sysclk_div_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (switch_evt),
    .last    (last_cnt),
    .tick    (clk_en)
  );

  assign div_active = run;

  // R3
  full_speed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !div_active |-> clk_en);

  // R10
  flag_follows_bus_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_end |=> $stable(div_active));

endmodule

// File: tb/sysclk_divider_bench.sv
module sysclk_divider_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel_wdata = '0;
  logic       sel_we = 1'b0;
  logic       bus_end = 1'b0;
  logic       clk_en;
  logic       div_active;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sysclk_divider u_sysclk_divider (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_wdata  (sel_wdata),
    .sel_we     (sel_we),
    .bus_end    (bus_end),
    .clk_en     (clk_en),
    .div_active (div_active)
  );

  // Vector table: code to write, expected period in base clocks.
  localparam int NVEC = 8;
  localparam logic [2:0] VEC_CODE [NVEC] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd0, 3'd6, 3'd7};
  localparam int         VEC_PER  [NVEC] = '{2, 4, 8, 16, 32, 1, 1, 1};

  task automatic check1(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Observe ncyc cycles starting at the current negedge. Period per, phase
  // offset ph. Optionally pulse bus_end at be_at and write wcode at wr_at.
  task automatic observe(input int per, input int ph, input int ncyc,
                         input int be_at, input int wr_at, input logic [2:0] wcode,
                         input string tag);
    bit ok = 1;
    int act = 0, exp = 0;
    for (int i = 0; i < ncyc; i++) begin
      bus_end   = (i == be_at);
      sel_we    = (i == wr_at);
      sel_wdata = wcode;
      #1;
      if (ok && ((clk_en !== (((i + ph) % per) == per - 1)) ||
                 (div_active !== (per > 1)))) begin
        ok  = 0;
        act = {30'd0, div_active, clk_en};
        exp = {30'd0, (per > 1), (((i + ph) % per) == per - 1)};
      end
      @(negedge clk);
    end
    bus_end = 0;
    sel_we  = 0;
    check1(ok, tag, act, exp);
  endtask

  // Stage a code and apply it with bus_end; returns at cycle index 0.
  task automatic switch_to(input logic [2:0] code);
    sel_we = 1; sel_wdata = code;
    @(negedge clk);
    sel_we = 0; bus_end = 1;
    @(negedge clk);
    bus_end = 0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check1(clk_en === 1'b1 && div_active === 1'b0, "R1 in reset", {div_active, clk_en}, 1);
    rst_n = 1;
    @(negedge clk);
    observe(1, 0, 4, -1, -1, 3'd0, "R1 after reset");

    // Table walk: R2, R3, R4, R7, R10
    for (int v = 0; v < NVEC; v++) begin
      switch_to(VEC_CODE[v]);
      observe(VEC_PER[v], 0, 2 * VEC_PER[v] + 2, -1, -1, 3'd0,
              (VEC_PER[v] > 1) ? "R2/R7/R10 divided" : "R3/R4 full speed");
    end

    // R5: staged write without bus_end changes nothing
    observe(1, 0, 10, -1, 0, 3'd3, "R5 staged only");
    observe(1, 0, 1, 0, -1, 3'd0, "R5 bus_end edge");
    observe(8, 0, 16, -1, -1, 3'd0, "R7 first period full");

    // R6: writing 000 waits for bus_end
    observe(8, 0, 16, -1, 0, 3'd0, "R6 divided continues");
    observe(8, 0, 1, 0, -1, 3'd0, "R6 bus_end edge");
    observe(1, 0, 6, -1, -1, 3'd0, "R6 back to full speed");

    // R9: bus_end without change keeps phase
    switch_to(3'd2);
    observe(4, 0, 12, 1, -1, 3'd0, "R9 phase kept");
    observe(4, 0, 8, 2, -1, 3'd0, "R8 single pulses");

    // R5: write on the same cycle as bus_end is held over
    switch_to(3'd0);
    observe(1, 0, 1, 0, 0, 3'd2, "R5 same-cycle write");
    observe(1, 0, 5, -1, -1, 3'd0, "R5 held over");
    observe(1, 0, 1, 0, -1, 3'd0, "R5 next bus_end");
    observe(4, 0, 8, -1, -1, 3'd0, "R5 applied");

    // R1: reset in divided mode clears the staged field
    switch_to(3'd3);
    observe(8, 0, 3, -1, -1, 3'd0, "R1 pre-reset");
    rst_n = 0;
    #1;
    check1(clk_en === 1'b1 && div_active === 1'b0, "R1 mid reset", {div_active, clk_en}, 1);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    observe(1, 0, 1, 0, -1, 3'd0, "R1 bus_end after reset");
    observe(1, 0, 6, -1, -1, 3'd0, "R1 staged cleared");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule